// File: doc/BRIEF.md
# Reset Synchronizer and Clock-Domain Reset Converter

This block turns a reset that bears no fixed relation to a destination clock into one that the logic of that clock domain can use safely. It is placed at the boundary of every clock domain that receives a reset from elsewhere: a board-level reset, the output of another domain, or a clock generator's "not yet locked" flag.

A parameter picks one of two flavours. In the asynchronous flavour the output follows a rising input at once, with no clock edge needed. Release is held back until a short register chain has clocked out the deasserted value. In the synchronous flavour the input is simply shifted through the register chain, so both edges arrive a fixed number of destination cycles late and a pulse that falls between edges is never seen.

When the reset comes from a domain whose own resets are synchronous, an optional register clocked by the source clock samples it first to remove glitches. When source and destination are the same domain, a parameter removes all logic and the reset passes straight through. Every flip-flop powers up holding the asserted value, so the output is asserted from time zero.

Top module: `rstx_conv`

## Requirements
- R1: With ASYNC_MODE=1, rst_out goes high in the same cycle in which rst_in goes high, before any dst_clk edge, and stays high while rst_in is high.
- R2: With ASYNC_MODE=1, after rst_in falls, rst_out stays high through the first rising dst_clk edge and goes low at the second. This holds even when rst_in was high for only part of a clock period between two edges.
- R3: With ASYNC_MODE=0 and no source register, every value of rst_in sampled on a rising dst_clk edge appears on rst_out exactly two edges later. A pulse that lies wholly between two edges leaves rst_out low.
- R4: With SRC_SYNC_STAGE=1, rst_in is first sampled on a rising src_clk edge. When src_clk rises a quarter period after dst_clk, every edge of rst_out arrives one dst_clk cycle later than under R3, and a pulse between src_clk edges is filtered out.
- R5: All registers power up asserted. With rst_in held low from time zero, rst_out is high until the chain releases it: two dst_clk edges without the source register, three with it.
- R6: With SAME_DOMAIN=1, rst_out equals rst_in at all times, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Clock of the domain the reset comes from; used only by the optional source register |
| dst_clk | input | 1 | Clock of the domain that receives the reset |
| rst_in | input | 1 | Incoming reset, active high, not aligned to dst_clk |
| rst_out | output | 1 | Reset for the destination domain, active high |

## Verification
Each stimulus is launched two nanoseconds after a falling dst_clk edge. From there, the chain output is due two rising edges later, or three when the source register is present. Asynchronous assertion and the bypass path are due within a nanosecond of the input change. The driver pushes one expected value for each configuration per cycle index into a scoreboard. It also pushes the last cycle in which the old value must still be visible, so a result that is a cycle early or a cycle late fails. The monitor samples on falling dst_clk edges and compares items whose cycle has come. Immediate responses are checked one nanosecond after the stimulus, before any clock edge can intervene.

// File: rtl/rstx_pkg.sv
package rstx_pkg;

    typedef enum logic {
        RSTX_SYNC_CHAIN = 1'b0,
        RSTX_ASYNC_SET  = 1'b1
    } rstx_mode_e;

    localparam int unsigned RSTX_MIN_STAGES = 2;

    function automatic rstx_mode_e rstx_mode(input bit async_sel);
        return async_sel ? RSTX_ASYNC_SET : RSTX_SYNC_CHAIN;
    endfunction

    function automatic int unsigned rstx_depth(input int unsigned req);
        return (req < RSTX_MIN_STAGES) ? RSTX_MIN_STAGES : req;
    endfunction

endpackage

// File: rtl/rstx_src_stage.sv
module rstx_src_stage (
    input  logic src_clk,
    input  logic rst_d,
    output logic rst_q
);

    // Powers up asserted so the destination never sees an early release.
    logic hold_q = 1'b1;

    always_ff @(posedge src_clk) begin
        hold_q <= rst_d;
    end

    assign rst_q = hold_q;

endmodule

// File: rtl/rstx_dst_chain.sv
module rstx_dst_chain
    import rstx_pkg::*;
#(
    parameter int unsigned STAGES = 2,
    parameter rstx_mode_e  MODE   = RSTX_SYNC_CHAIN
) (
    input  logic dst_clk,
    input  logic rst_d,
    output logic rst_q
);

    localparam int unsigned TOP = STAGES - 1;

    logic [TOP:0] chain_q = '1;
    logic [1:0]   warm_q  = '0;

    // Edges seen since power-up, saturating; gates the checks below.
    always_ff @(posedge dst_clk) begin
        if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    assign rst_q = chain_q[TOP];

    generate
        if (MODE == RSTX_ASYNC_SET) begin : g_async
            always_ff @(posedge dst_clk or posedge rst_d) begin
                if (rst_d) chain_q <= '1;
                else       chain_q <= {chain_q[TOP-1:0], 1'b0};
            end

            p_assert_now_r1: assert property (@(posedge dst_clk)
                disable iff (warm_q == 2'd0)
                rst_d |-> rst_q);

            p_release_r2: assert property (@(posedge dst_clk)
                disable iff (warm_q == 2'd0)
                $fell(rst_q) |-> (!rst_d && !$past(rst_d)));

            for (genvar i = 0; i < TOP; i++) begin : g_thermo
                p_thermo_r2: assert property (@(posedge dst_clk)
                    disable iff (warm_q == 2'd0)
                    !chain_q[i+1] |-> !chain_q[i]);
            end
        end else begin : g_sync
            always_ff @(posedge dst_clk) begin
                chain_q <= {chain_q[TOP-1:0], rst_d};
            end

            if (STAGES == 2) begin : g_lag
                p_lag_r3: assert property (@(posedge dst_clk)
                    disable iff (warm_q < 2'd2)
                    rst_q == $past(rst_d, 2));
            end
        end
    endgenerate

endmodule

// File: rtl/rstx_conv.sv
module rstx_conv
    import rstx_pkg::*;
#(
    parameter bit          ASYNC_MODE     = 1'b0,
    parameter bit          SAME_DOMAIN    = 1'b0,
    parameter bit          SRC_SYNC_STAGE = 1'b1,
    parameter int unsigned STAGES         = 2
) (
    input  logic src_clk,
    input  logic dst_clk,
    input  logic rst_in,
    output logic rst_out
);

    localparam rstx_mode_e  MODE  = rstx_mode(ASYNC_MODE);
    localparam int unsigned DEPTH = rstx_depth(STAGES);

    generate
        if (SAME_DOMAIN) begin : g_bypass
            assign rst_out = rst_in;
        end else begin : g_conv
            logic mid_rst;

            if (SRC_SYNC_STAGE) begin : g_src
                rstx_src_stage u_src (
                    .src_clk (src_clk),
                    .rst_d   (rst_in),
                    .rst_q   (mid_rst)
                );
            end else begin : g_nosrc
                assign mid_rst = rst_in;
            end

            rstx_dst_chain #(
                .STAGES (DEPTH),
                .MODE   (MODE)
            ) u_chain (
                .dst_clk (dst_clk),
                .rst_d   (mid_rst),
                .rst_q   (rst_out)
            );
        end
    endgenerate

endmodule

// File: tb/rstx_conv_tb_top.sv
module rstx_conv_tb_top;

    localparam int U_X = 0;  // sync chain with source register (defaults)
    localparam int U_A = 1;  // async set, no source register
    localparam int U_S = 2;  // sync chain, no source register
    localparam int U_B = 3;  // same-domain bypass

    logic src_clk = 1'b0;
    logic dst_clk = 1'b0;
    logic rst_in  = 1'b0;
    logic out_x, out_a, out_s, out_b;

    int cyc   = 0;
    int n_chk = 0;
    int n_err = 0;
    bit ended = 1'b0;

    typedef struct {
        int    due;
        int    unit;
        logic  exp;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    // 50 MHz destination clock; source clock rises 5 ns after it.
    always #10 dst_clk = ~dst_clk;
    initial begin
        #5;
        forever #10 src_clk = ~src_clk;
    end

    always @(posedge dst_clk) cyc <= cyc + 1;

    rstx_conv dut_i (
        .src_clk (src_clk), .dst_clk (dst_clk), .rst_in (rst_in), .rst_out (out_x));

    rstx_conv #(.ASYNC_MODE(1'b1), .SRC_SYNC_STAGE(1'b0)) dut_async_i (
        .src_clk (src_clk), .dst_clk (dst_clk), .rst_in (rst_in), .rst_out (out_a));

    rstx_conv #(.ASYNC_MODE(1'b0), .SRC_SYNC_STAGE(1'b0)) dut_sync_i (
        .src_clk (src_clk), .dst_clk (dst_clk), .rst_in (rst_in), .rst_out (out_s));

    rstx_conv #(.SAME_DOMAIN(1'b1)) dut_byp_i (
        .src_clk (src_clk), .dst_clk (dst_clk), .rst_in (rst_in), .rst_out (out_b));

    function automatic logic pick(input int unit);
        case (unit)
            U_X:     return out_x;
            U_A:     return out_a;
            U_S:     return out_s;
            default: return out_b;
        endcase
    endfunction

    task automatic check(input int unit, input logic exp, input string tag);
        n_chk++;
        if (pick(unit) !== exp) begin
            n_err++;
            $display("FAIL %s unit=%0d cyc=%0d actual=%b expected=%b",
                     tag, unit, cyc, pick(unit), exp);
        end
    endtask

    task automatic expect_at(input int due, input int unit, input logic exp, input string tag);
        sb_q.push_back('{due, unit, exp, tag});
    endtask

    task automatic to_slot();
        @(negedge dst_clk);
        #2;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    // Monitor: compare every scoreboard item whose cycle has come.
    always @(negedge dst_clk) begin
        for (int i = sb_q.size() - 1; i >= 0; i--) begin
            if (sb_q[i].due <= cyc) begin
                if (sb_q[i].due < cyc) begin
                    n_chk++;
                    n_err++;
                    $display("FAIL %s unit=%0d missed cyc=%0d actual=x expected=%b",
                             sb_q[i].tag, sb_q[i].unit, sb_q[i].due, sb_q[i].exp);
                end else begin
                    check(sb_q[i].unit, sb_q[i].exp, sb_q[i].tag);
                end
                sb_q.delete(i);
            end
        end
    end

    initial begin
        int n;
        // R5: power-up values, input low from time zero
        #1;
        check(U_X, 1'b1, "R5 power-up");
        check(U_A, 1'b1, "R5 power-up");
        check(U_S, 1'b1, "R5 power-up");
        check(U_B, 1'b0, "R6 bypass at power-up");
        expect_at(1, U_S, 1'b1, "R5 still held");
        expect_at(2, U_S, 1'b0, "R5 release");
        expect_at(1, U_A, 1'b1, "R5 still held");
        expect_at(2, U_A, 1'b0, "R5 release");
        expect_at(1, U_X, 1'b1, "R5 still held");
        expect_at(2, U_X, 1'b1, "R5 still held");
        expect_at(3, U_X, 1'b0, "R5 release");
        repeat (5) @(negedge dst_clk);

        // Assertion edge
        to_slot();
        n = cyc;
        rst_in = 1'b1;
        #1;
        check(U_A, 1'b1, "R1 immediate assert");
        check(U_B, 1'b1, "R6 bypass follows");
        expect_at(n + 1, U_A, 1'b1, "R1 held");
        expect_at(n + 1, U_S, 1'b0, "R3 not yet");
        expect_at(n + 2, U_S, 1'b1, "R3 assert lag");
        expect_at(n + 2, U_X, 1'b0, "R4 not yet");
        expect_at(n + 3, U_X, 1'b1, "R4 assert lag");
        repeat (6) @(negedge dst_clk);

        // Release edge
        to_slot();
        n = cyc;
        rst_in = 1'b0;
        #1;
        check(U_B, 1'b0, "R6 bypass follows");
        check(U_A, 1'b1, "R2 no immediate release");
        expect_at(n + 1, U_A, 1'b1, "R2 held one edge");
        expect_at(n + 2, U_A, 1'b0, "R2 release");
        expect_at(n + 1, U_S, 1'b1, "R3 held");
        expect_at(n + 2, U_S, 1'b0, "R3 release lag");
        expect_at(n + 2, U_X, 1'b1, "R4 held");
        expect_at(n + 3, U_X, 1'b0, "R4 release lag");
        repeat (6) @(negedge dst_clk);

        // Pulse wholly between clock edges
        to_slot();
        n = cyc;
        rst_in = 1'b1;
        #1;
        check(U_A, 1'b1, "R1 short pulse assert");
        #3;
        rst_in = 1'b0;
        #1;
        check(U_A, 1'b1, "R2 held after mid-cycle drop");
        check(U_B, 1'b0, "R6 bypass follows");
        expect_at(n + 1, U_A, 1'b1, "R2 mid-cycle held");
        expect_at(n + 2, U_A, 1'b0, "R2 mid-cycle release");
        expect_at(n + 1, U_S, 1'b0, "R3 pulse unsampled");
        expect_at(n + 2, U_S, 1'b0, "R3 pulse unsampled");
        expect_at(n + 3, U_S, 1'b0, "R3 pulse unsampled");
        expect_at(n + 2, U_X, 1'b0, "R4 glitch filtered");
        expect_at(n + 3, U_X, 1'b0, "R4 glitch filtered");
        expect_at(n + 4, U_X, 1'b0, "R4 glitch filtered");
        repeat (6) @(negedge dst_clk);

        // One-cycle pulse
        to_slot();
        n = cyc;
        rst_in = 1'b1;
        expect_at(n + 1, U_S, 1'b0, "R3 one-cycle pulse");
        expect_at(n + 2, U_S, 1'b1, "R3 one-cycle pulse");
        expect_at(n + 3, U_S, 1'b0, "R3 one-cycle pulse");
        expect_at(n + 2, U_X, 1'b0, "R4 one-cycle pulse");
        expect_at(n + 3, U_X, 1'b1, "R4 one-cycle pulse");
        expect_at(n + 4, U_X, 1'b0, "R4 one-cycle pulse");
        expect_at(n + 2, U_A, 1'b1, "R2 one-cycle pulse held");
        expect_at(n + 3, U_A, 1'b0, "R2 one-cycle pulse release");
        to_slot();
        rst_in = 1'b0;

        while (sb_q.size() > 0) @(negedge dst_clk);
        #1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge dst_clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog cyc=%0d actual=running expected=done", cyc);
        finish_run();
    end

endmodule